// File: doc/BRIEF.md
# System-Management Instruction Gate and Mode Controller

This block sits in the decode stage of an x86-style core and handles the system-management instruction group. Each of these instructions arrives as its second opcode byte (the byte after 0F), together with the ModR/M reg field. The block decides whether the instruction may run, based on four inputs:

- the management-interrupt enable;
- the size of the management address region;
- the current privilege level;
- an access-control bit.

It then reports either an invalid-opcode fault or a decoded operation. The operation is a save or restore of a segment register, the LDT register or the task register, a software entry, or a resume. Save and restore operations also raise a flag that marks an 80-bit transfer. The data movement and the contents of the state header are handled elsewhere.

The block also tracks whether the core is running a management routine. A hardware management request is taken at once when the core is outside a routine. A request that arrives while a routine runs is held until the routine has been left. All decode results and mode pulses appear one clock after the inputs that cause them.

Top module: `smm_gate`

## Requirements
- R1: With `insn_valid` high, the opcode byte selects `op_sel` one cycle later: 78h save segment=1, 79h restore segment=2, 7Ah save LDTR=3, 7Bh restore LDTR=4, 7Ch save task register=5, 7Dh restore task register=6, 38h software entry=7, AAh resume=8. A legal instruction raises `op_valid`. A faulting instruction raises `ud_fault` with `op_sel`=0.
- R2: The six save/restore forms and resume are legal only when all of these hold: enable=1, region size nonzero, privilege 0, and either the access bit=1 or `in_smm`=1. Otherwise they fault.
- R3: Software entry (38h) is legal only when enable=1, region size nonzero, privilege 0, access bit=1 and `in_smm`=0. Being inside a routine never stands in for the access bit.
- R4: The reg field codes segments as ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. Codes 6 and 7 fault on both segment forms. Restore with CS (1) faults. A legal segment form reports the code on `op_sreg`; every other case drives `op_sreg` to 0.
- R5: The LDTR and task-register forms fault unless the reg field is 000.
- R6: `xfer80` is high, together with `op_valid`, exactly for a legal save/restore form (op_sel 1 to 6).
- R7: A legal software entry pulses `smm_enter` and sets `in_smm`. A legal resume while `in_smm`=1 pulses `smm_exit` and clears `in_smm`. A legal resume outside a routine changes nothing and gives no pulse.
- R8: `hw_smi` while `in_smm`=0 (and no legal software entry in the same cycle) pulses `smm_enter` and sets `in_smm` on the next cycle.
- R9: `hw_smi` while `in_smm`=1 is held as a single pending request; further requests do not stack. Once outside a routine, the held request is serviced on the first cycle with `retire` high or a new `hw_smi`. That service pulses `smm_enter`, sets `in_smm` and clears the hold.
- R10: When a legal software entry and `hw_smi` occur in the same cycle, the software entry wins and the hardware request becomes pending.
- R11: After reset `in_smm` is 0, nothing is pending and all outputs are 0. Opcodes outside the group produce neither a fault nor an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction strobe |
| opcode | input | 8 | Second opcode byte |
| modrm_reg | input | 3 | ModR/M reg field |
| cfg_smi_en | input | 1 | Management interrupt enable |
| cfg_region_size | input | RGN_W | Management region size |
| cfg_access | input | 1 | Access-control bit |
| cfg_cpl | input | 2 | Current privilege level |
| hw_smi | input | 1 | Hardware management request |
| retire | input | 1 | Instruction retire pulse |
| ud_fault | output | 1 | Invalid-opcode exception |
| op_valid | output | 1 | Legal group operation decoded |
| op_sel | output | 4 | Operation select code |
| op_sreg | output | 3 | Segment code for segment forms |
| xfer80 | output | 1 | 80-bit transfer indicator |
| smm_enter | output | 1 | Routine entry pulse |
| smm_exit | output | 1 | Routine exit pulse |
| in_smm | output | 1 | Inside management routine |

## Verification
The assertions hold on every cycle for the following:

- a fault and an operation never appear together;
- `xfer80` appears only with a save/restore select;
- an entry or exit pulse always agrees with the mode flag it leaves behind;
- no entry pulse occurs while a routine is active;
- any group instruction issued at nonzero privilege always faults.

Some behaviour can only be shown by the bench's scenarios. This covers the ordering between a held hardware request, the resume that releases it and the retire that services it. It also covers the same-cycle race between software entry and a hardware request, and the segment-code exceptions.

// File: rtl/smm_gate.sv
module smm_gate #(
  parameter int RGN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  input  logic [7:0]       opcode,
  input  logic [2:0]       modrm_reg,
  input  logic             cfg_smi_en,
  input  logic [RGN_W-1:0] cfg_region_size,
  input  logic             cfg_access,
  input  logic [1:0]       cfg_cpl,
  input  logic             hw_smi,
  input  logic             retire,
  output logic             ud_fault,
  output logic             op_valid,
  output logic [3:0]       op_sel,
  output logic [2:0]       op_sreg,
  output logic             xfer80,
  output logic             smm_enter,
  output logic             smm_exit,
  output logic             in_smm
);

  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_SV_SEG = 4'd1, OP_RS_SEG = 4'd2, OP_SV_LDT = 4'd3,
    OP_RS_LDT = 4'd4, OP_SV_TSK = 4'd5, OP_RS_TSK = 4'd6, OP_ENTER = 4'd7,
    OP_RESUME = 4'd8
  } op_e;

  localparam logic [2:0] SEG_CS = 3'd1;
  localparam logic [2:0] SEG_MAX = 3'd5;

  logic in_q, pend_q;
  logic base_ok, gen_ok, ent_ok;
  logic grp, ok, is_seg, is_xfer;
  op_e  sel;

  assign base_ok = cfg_smi_en && (|cfg_region_size) && (cfg_cpl == 2'd0);
  assign gen_ok  = base_ok && (cfg_access || in_q);
  assign ent_ok  = base_ok && cfg_access && !in_q;

  always_comb begin
    grp = 1'b1;
    ok = 1'b0;
    sel = OP_NONE;
    is_seg = 1'b0;
    is_xfer = 1'b1;
    unique case (opcode)
      8'h78: begin sel = OP_SV_SEG; is_seg = 1'b1; ok = gen_ok && modrm_reg <= SEG_MAX; end
      8'h79: begin
        sel = OP_RS_SEG; is_seg = 1'b1;
        ok = gen_ok && modrm_reg <= SEG_MAX && modrm_reg != SEG_CS;
      end
      8'h7A: begin sel = OP_SV_LDT; ok = gen_ok && modrm_reg == 3'd0; end
      8'h7B: begin sel = OP_RS_LDT; ok = gen_ok && modrm_reg == 3'd0; end
      8'h7C: begin sel = OP_SV_TSK; ok = gen_ok && modrm_reg == 3'd0; end
      8'h7D: begin sel = OP_RS_TSK; ok = gen_ok && modrm_reg == 3'd0; end
      8'h38: begin sel = OP_ENTER;  ok = ent_ok; is_xfer = 1'b0; end
      8'hAA: begin sel = OP_RESUME; ok = gen_ok; is_xfer = 1'b0; end
      default: begin grp = 1'b0; is_xfer = 1'b0; end
    endcase
  end

  logic hit, sw_enter, resume_ok, hw_now, svc;
  assign hit       = insn_valid && grp;
  assign sw_enter  = hit && ok && sel == OP_ENTER;
  assign resume_ok = hit && ok && sel == OP_RESUME;
  assign hw_now    = hw_smi && !in_q && !sw_enter;
  assign svc       = pend_q && !in_q && !sw_enter && (retire || hw_smi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ud_fault  <= 1'b0;
      op_valid  <= 1'b0;
      op_sel    <= OP_NONE;
      op_sreg   <= 3'd0;
      xfer80    <= 1'b0;
      smm_enter <= 1'b0;
      smm_exit  <= 1'b0;
      in_q      <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      ud_fault  <= hit && !ok;
      op_valid  <= hit && ok;
      op_sel    <= (hit && ok) ? sel : OP_NONE;
      op_sreg   <= (hit && ok && is_seg) ? modrm_reg : 3'd0;
      xfer80    <= hit && ok && is_xfer;
      smm_enter <= sw_enter || hw_now || svc;
      smm_exit  <= resume_ok && in_q;
      if (sw_enter || hw_now || svc) in_q <= 1'b1;
      else if (resume_ok)            in_q <= 1'b0;
      if (hw_smi && (in_q || sw_enter)) pend_q <= 1'b1;
      else if (hw_now || svc)           pend_q <= 1'b0;
    end
  end

  assign in_smm = in_q;

endmodule

// File: rtl/smm_gate_chk.sv
module smm_gate_chk #(
  parameter int RGN_W = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_valid,
  input logic [7:0] opcode,
  input logic [1:0] cfg_cpl,
  input logic       ud_fault,
  input logic       op_valid,
  input logic [3:0] op_sel,
  input logic       xfer80,
  input logic       smm_enter,
  input logic       smm_exit,
  input logic       in_smm
);

  logic grp_op;
  assign grp_op = (opcode >= 8'h78 && opcode <= 8'h7D) || opcode == 8'h38 || opcode == 8'hAA;

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> !op_valid && op_sel == 4'd0); // R1
  AST_CPL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && grp_op && cfg_cpl != 2'd0 |=> ud_fault); // R2
  AST_XFER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer80 |-> op_valid && op_sel >= 4'd1 && op_sel <= 4'd6); // R6
  AST_ENTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    smm_enter |-> in_smm && !smm_exit); // R7
  AST_EXIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    smm_exit |-> !in_smm && $past(in_smm)); // R7
  AST_NO_REENTER: assert property (@(posedge clk) disable iff (!rst_n)
    in_smm |=> !smm_enter); // R9

endmodule

bind smm_gate smm_gate_chk #(.RGN_W(RGN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .opcode(opcode),
  .cfg_cpl(cfg_cpl), .ud_fault(ud_fault), .op_valid(op_valid), .op_sel(op_sel),
  .xfer80(xfer80), .smm_enter(smm_enter), .smm_exit(smm_exit), .in_smm(in_smm)
);

// File: tb/tb_smm_gate.sv
module tb_smm_gate;
  localparam int CLK_P = 10;
  localparam int RGN_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [2:0] modrm_reg = 3'd0;
  logic cfg_smi_en = 1'b1;
  logic [RGN_W-1:0] cfg_region_size = 32'h1000;
  logic cfg_access = 1'b1;
  logic [1:0] cfg_cpl = 2'd0;
  logic hw_smi = 1'b0;
  logic retire = 1'b0;
  logic ud_fault, op_valid, xfer80, smm_enter, smm_exit, in_smm;
  logic [3:0] op_sel;
  logic [2:0] op_sreg;

  smm_gate #(.RGN_W(RGN_W)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  bit m_in = 0, m_pend = 0;

  task automatic compare(input string tag, input logic [13:0] exp_v);
    logic [13:0] act_v;
    act_v = {ud_fault, op_valid, op_sel, op_sreg, xfer80, smm_enter, smm_exit, in_smm};
    vectors++;
    if (act_v !== exp_v) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, act_v, exp_v);
    end
  endtask

  task automatic vec(input string tag, input logic v, input logic [7:0] op,
                     input logic [2:0] r, input logic hw, input logic rt);
    bit known, legal, seg, xf, sw, res, hwe, ent, ext;
    int code;
    bit base;
    insn_valid = v; opcode = op; modrm_reg = r; hw_smi = hw; retire = rt;
    base = cfg_smi_en && cfg_region_size != 0 && cfg_cpl == 0;
    known = 1; seg = 0; xf = 0; code = 0; legal = 0;
    if (op == 8'h78 || op == 8'h79) begin
      seg = 1; xf = 1; code = (op == 8'h78) ? 1 : 2;
      legal = base && (cfg_access || m_in) && r < 6 && !(op == 8'h79 && r == 1);
    end else if (op >= 8'h7A && op <= 8'h7D) begin
      xf = 1; code = op - 8'h77;
      legal = base && (cfg_access || m_in) && r == 0;
    end else if (op == 8'h38) begin
      code = 7; legal = base && cfg_access && !m_in;
    end else if (op == 8'hAA) begin
      code = 8; legal = base && (cfg_access || m_in);
    end else known = 0;
    if (!v) known = 0;
    sw  = known && legal && code == 7;
    res = known && legal && code == 8;
    hwe = !m_in && !sw && (hw || (m_pend && rt));
    ent = sw || hwe;
    ext = res && m_in;
    @(posedge clk);
    if (hw && (m_in || sw)) m_pend = 1; else if (hwe) m_pend = 0;
    if (ent) m_in = 1; else if (res) m_in = 0;
    @(negedge clk);
    compare(tag, {known && !legal, known && legal,
                  (known && legal) ? 4'(code) : 4'd0,
                  (known && legal && seg) ? r : 3'd0,
                  known && legal && xf, ent, ext, m_in});
    insn_valid = 0; hw_smi = 0; retire = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R11 reset", 14'd0);
    rst_n = 1'b1;
    @(negedge clk);
    vec("R11 foreign opcode", 1, 8'h00, 3'd0, 0, 0);
    vec("R1 R4 save DS", 1, 8'h78, 3'd3, 0, 0);
    vec("R1 R6 restore GS", 1, 8'h79, 3'd5, 0, 0);
    vec("R4 save CS", 1, 8'h78, 3'd1, 0, 0);
    vec("R4 restore CS", 1, 8'h79, 3'd1, 0, 0);
    vec("R4 save code6", 1, 8'h78, 3'd6, 0, 0);
    vec("R4 restore code7", 1, 8'h79, 3'd7, 0, 0);
    vec("R1 R6 save LDTR", 1, 8'h7A, 3'd0, 0, 0);
    vec("R5 restore LDTR reg1", 1, 8'h7B, 3'd1, 0, 0);
    vec("R1 save task", 1, 8'h7C, 3'd0, 0, 0);
    vec("R5 restore task reg4", 1, 8'h7D, 3'd4, 0, 0);
    vec("R1 no strobe", 0, 8'h78, 3'd0, 0, 0);
    cfg_cpl = 2'd3;
    vec("R2 cpl3", 1, 8'h7D, 3'd0, 0, 0);
    cfg_cpl = 2'd0; cfg_smi_en = 0;
    vec("R2 disabled", 1, 8'h78, 3'd0, 0, 0);
    cfg_smi_en = 1; cfg_region_size = 0;
    vec("R2 zero region", 1, 8'hAA, 3'd0, 0, 0);
    cfg_region_size = 32'h1000;
    vec("R7 resume outside", 1, 8'hAA, 3'd0, 0, 0);
    cfg_access = 0;
    vec("R2 no access outside", 1, 8'h78, 3'd2, 0, 0);
    vec("R3 entry no access", 1, 8'h38, 3'd0, 0, 0);
    cfg_access = 1;
    vec("R3 R7 entry", 1, 8'h38, 3'd5, 0, 0);
    vec("R3 entry in SMM", 1, 8'h38, 3'd0, 0, 0);
    cfg_access = 0;
    vec("R2 save in SMM", 1, 8'h78, 3'd4, 0, 0);
    vec("R9 hw in SMM", 0, 8'h00, 3'd0, 1, 0);
    vec("R9 hw again", 0, 8'h00, 3'd0, 1, 1);
    vec("R7 resume", 1, 8'hAA, 3'd0, 0, 0);
    vec("R9 idle pending", 0, 8'h00, 3'd0, 0, 0);
    vec("R9 retire service", 0, 8'h00, 3'd0, 0, 1);
    vec("R9 no second", 0, 8'h00, 3'd0, 0, 1);
    vec("R7 resume hw", 1, 8'hAA, 3'd0, 0, 1);
    vec("R9 nothing left", 0, 8'h00, 3'd0, 0, 1);
    vec("R8 hw outside", 0, 8'h00, 3'd0, 1, 0);
    vec("R7 resume", 1, 8'hAA, 3'd0, 0, 0);
    cfg_access = 1;
    vec("R10 race", 1, 8'h38, 3'd0, 1, 0);
    vec("R7 resume", 1, 8'hAA, 3'd0, 0, 0);
    vec("R10 pending serviced", 0, 8'h00, 3'd0, 0, 1);
    vec("R7 resume", 1, 8'hAA, 3'd0, 0, 0);
    vec("R11 foreign FF", 1, 8'hFF, 3'd7, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule